// File: doc/BRIEF.md
# Masked Vector Compare-Execute Unit

This unit keeps two integer vector registers (called A and B), a per-element mask and a vector length setting. It runs element-wise operations over them, one element per clock, through a short fixed pipeline. A not-equal compare of A against a scalar fills the mask. A masked subtract then writes A[i] - B[i] back into A, but only in the lanes whose mask bit is set. An unmasked add writes A[i] + B[i] into every lane below the vector length. Two configuration commands set the vector length and restore an all-ones mask.

Software loads elements over a load port and reads them back over a combinational read port. It then issues commands and waits for the one-cycle done pulse. The command port and the load port are both valid/ready. Ready is low for the whole of a streaming operation. An offer made while ready is low is dropped, not held: the offering side must keep valid high until it sees ready high on a clock edge. Only a transfer made with ready high has any effect.

Top module: `vmask_exec`

## Requirements
- R1: After reset the mask reads all ones, the vector length reads 64, and busy, done and cmd_ready read 0, 0 and 1. Element contents are not reset.
- R2: A load with ld_valid and ld_ready both high writes ld_data into element ld_idx of register A (ld_sel=0) or register B (ld_sel=1). The read port returns element rd_idx of A (rd_sel=0) or B (rd_sel=1) combinationally.
- R3: Command op 0 (compare) with scalar cmd_arg sets mask bit i to (A[i] != cmd_arg) for every i below the vector length. Mask bits at or above the vector length are unchanged.
- R4: Op 1 (masked subtract) writes A[i] - B[i], modulo 2^64, into A[i] for each i below the vector length whose mask bit is 1. Every other element of A, all of B and the mask are unchanged.
- R5: Op 2 (unmasked add) writes A[i] + B[i], modulo 2^64, into A[i] for every i below the vector length, whatever the mask holds. Elements at or above the length are unchanged.
- R6: Op 4 sets the vector length from cmd_arg, clamped to the range 1..64 (0 gives 1, anything above 64 gives 64). The new length reads back on vl_out in the cycle after acceptance.
- R7: Op 3 sets all 64 mask bits to 1, visible in the cycle after acceptance.
- R8: If a streaming op (0, 1 or 2) is accepted at the end of cycle 0, busy is high in cycles 1 through VL+1. Done is high in cycle VL+2 only, and all results are readable in that cycle.
- R9: While busy is high, cmd_ready and ld_ready are low. Commands and loads offered then leave the registers, the mask and the length unchanged.
- R10: Op codes 5, 6 and 7 are accepted and change nothing. Ops 3 and 4 never raise busy or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_op | input | 3 | Operation code |
| cmd_arg | input | 64 | Scalar for compare, or length for op 4 |
| ld_valid | input | 1 | Element load offered |
| ld_ready | output | 1 | Load can be taken (idle) |
| ld_sel | input | 1 | Load target: 0 = A, 1 = B |
| ld_idx | input | 6 | Load element index |
| ld_data | input | 64 | Load element value |
| rd_sel | input | 1 | Read source: 0 = A, 1 = B |
| rd_idx | input | 6 | Read element index |
| rd_data | output | 64 | Read element value |
| mask_out | output | 64 | Current mask |
| vl_out | output | 7 | Current vector length |
| busy | output | 1 | Streaming operation in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that cmd_op and cmd_valid are known (never X) on every clock edge after reset. They also assume that reset is held long enough for the pipeline registers to clear. The stimulus drives every input a short time after the rising edge. It offers commands and loads while the unit is idle, and during busy only on purpose to probe R9. Compare scalars are drawn partly from values already stored in A, so that both mask outcomes occur. Vector lengths include the clamped extremes 1 and 64.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  typedef enum logic [2:0] {
    OP_CMPNE = 3'd0,
    OP_SUBM  = 3'd1,
    OP_ADD   = 3'd2,
    OP_MSET  = 3'd3,
    OP_SETVL = 3'd4
  } vop_e;
endpackage

// File: rtl/vmx_regs.sv
module vmx_regs #(
  parameter int ELEMS = 64,
  parameter int EW    = 64,
  localparam int IW   = $clog2(ELEMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic             ld_sel,
  input  logic [IW-1:0]    ld_idx,
  input  logic [EW-1:0]    ld_data,
  input  logic             wb_we,
  input  logic [IW-1:0]    wb_idx,
  input  logic [EW-1:0]    wb_data,
  input  logic             mk_we,
  input  logic [IW-1:0]    mk_idx,
  input  logic             mk_bit,
  input  logic             mk_setall,
  input  logic [IW-1:0]    rs_idx,
  output logic [EW-1:0]    rs_a,
  output logic [EW-1:0]    rs_b,
  output logic             rs_m,
  input  logic             rd_sel,
  input  logic [IW-1:0]    rd_idx,
  output logic [EW-1:0]    rd_data,
  output logic [ELEMS-1:0] mask
);
  logic [EW-1:0] va [ELEMS];
  logic [EW-1:0] vb [ELEMS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < ELEMS; i++) begin
      if (ld_we && !ld_sel && ld_idx == IW'(i)) va[i] <= ld_data;
      else if (wb_we && wb_idx == IW'(i))       va[i] <= wb_data;
      if (ld_we && ld_sel && ld_idx == IW'(i))  vb[i] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mk_setall) mask <= '1;
    else if (mk_we)          mask[mk_idx] <= mk_bit;
  end

  assign rs_a    = va[rs_idx];
  assign rs_b    = vb[rs_idx];
  assign rs_m    = mask[rs_idx];
  assign rd_data = rd_sel ? vb[rd_idx] : va[rd_idx];
endmodule

// File: rtl/vmx_issue.sv
module vmx_issue
  import vmx_pkg::*;
#(
  parameter int ELEMS = 64,
  parameter int EW    = 64,
  localparam int IW   = $clog2(ELEMS),
  localparam int LW   = $clog2(ELEMS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  vop_e          op_in,
  input  logic [EW-1:0] arg_in,
  input  logic [LW-1:0] vl,
  output logic          iss_valid,
  output logic [IW-1:0] iss_idx,
  output logic          iss_last,
  output vop_e          iss_op,
  output logic [EW-1:0] iss_arg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_idx   <= '0;
      iss_last  <= 1'b0;
      iss_op    <= OP_CMPNE;
      iss_arg   <= '0;
    end else if (start) begin
      iss_valid <= 1'b1;
      iss_idx   <= '0;
      iss_last  <= (vl == LW'(1));
      iss_op    <= op_in;
      iss_arg   <= arg_in;
    end else if (iss_valid) begin
      if (iss_last) begin
        iss_valid <= 1'b0;
      end else begin
        iss_idx  <= iss_idx + IW'(1);
        iss_last <= (LW'(iss_idx) + LW'(2) == vl);
      end
    end
  end
endmodule

// File: rtl/vmx_lane.sv
module vmx_lane
  import vmx_pkg::*;
#(
  parameter int ELEMS = 64,
  parameter int EW    = 64,
  localparam int IW   = $clog2(ELEMS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [IW-1:0] iss_idx,
  input  logic          iss_last,
  input  vop_e          iss_op,
  input  logic [EW-1:0] iss_arg,
  input  logic [EW-1:0] opa,
  input  logic [EW-1:0] opb,
  input  logic          mbit,
  output logic          ex_valid,
  output logic [IW-1:0] ex_idx,
  output logic          ex_last,
  output logic          ex_wa,
  output logic          ex_wm,
  output logic [EW-1:0] ex_data,
  output logic          ex_mbit
);
  logic          n_wa, n_wm, n_mbit;
  logic [EW-1:0] n_data;

  always_comb begin
    n_wa   = 1'b0;
    n_wm   = 1'b0;
    n_mbit = (opa != iss_arg);
    n_data = opa + opb;
    case (iss_op)
      OP_CMPNE: n_wm = 1'b1;
      OP_SUBM: begin
        n_data = opa - opb;
        n_wa   = mbit;
      end
      OP_ADD:  n_wa = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_idx   <= '0;
      ex_last  <= 1'b0;
      ex_wa    <= 1'b0;
      ex_wm    <= 1'b0;
      ex_data  <= '0;
      ex_mbit  <= 1'b0;
    end else begin
      ex_valid <= iss_valid;
      ex_idx   <= iss_idx;
      ex_last  <= iss_valid && iss_last;
      ex_wa    <= iss_valid && n_wa;
      ex_wm    <= iss_valid && n_wm;
      ex_data  <= n_data;
      ex_mbit  <= n_mbit;
    end
  end
endmodule

// File: rtl/vmask_exec.sv
module vmask_exec
  import vmx_pkg::*;
#(
  parameter int ELEMS = 64,
  parameter int EW    = 64,
  localparam int IW   = $clog2(ELEMS),
  localparam int LW   = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [EW-1:0]    cmd_arg,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic             ld_sel,
  input  logic [IW-1:0]    ld_idx,
  input  logic [EW-1:0]    ld_data,
  input  logic             rd_sel,
  input  logic [IW-1:0]    rd_idx,
  output logic [EW-1:0]    rd_data,
  output logic [ELEMS-1:0] mask_out,
  output logic [LW-1:0]    vl_out,
  output logic             busy,
  output logic             done
);
  logic          accept, start;
  vop_e          op;
  logic          iss_valid, iss_last;
  logic [IW-1:0] iss_idx;
  vop_e          iss_op;
  logic [EW-1:0] iss_arg;
  logic [EW-1:0] opa, opb;
  logic          mbit;
  logic          ex_valid, ex_last, ex_wa, ex_wm, ex_mbit;
  logic [IW-1:0] ex_idx;
  logic [EW-1:0] ex_data;
  logic [LW-1:0] vl_q;

  assign op        = vop_e'(cmd_op);
  assign busy      = iss_valid | ex_valid;
  assign cmd_ready = !busy;
  assign ld_ready  = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && (op == OP_CMPNE || op == OP_SUBM || op == OP_ADD);
  assign vl_out    = vl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q <= LW'(ELEMS);
      done <= 1'b0;
    end else begin
      done <= ex_valid && ex_last;
      if (accept && op == OP_SETVL) begin
        if (cmd_arg == '0)                vl_q <= LW'(1);
        else if (cmd_arg > EW'(ELEMS))    vl_q <= LW'(ELEMS);
        else                              vl_q <= cmd_arg[LW-1:0];
      end
    end
  end

  vmx_issue #(.ELEMS(ELEMS), .EW(EW)) u_issue (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op), .arg_in(cmd_arg),
    .vl(vl_q), .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_last(iss_last),
    .iss_op(iss_op), .iss_arg(iss_arg)
  );

  vmx_regs #(.ELEMS(ELEMS), .EW(EW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_we(ld_valid && ld_ready), .ld_sel(ld_sel), .ld_idx(ld_idx), .ld_data(ld_data),
    .wb_we(ex_wa), .wb_idx(ex_idx), .wb_data(ex_data),
    .mk_we(ex_wm), .mk_idx(ex_idx), .mk_bit(ex_mbit),
    .mk_setall(accept && op == OP_MSET),
    .rs_idx(iss_idx), .rs_a(opa), .rs_b(opb), .rs_m(mbit),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data), .mask(mask_out)
  );

  vmx_lane #(.ELEMS(ELEMS), .EW(EW)) u_lane (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_idx(iss_idx),
    .iss_last(iss_last), .iss_op(iss_op), .iss_arg(iss_arg),
    .opa(opa), .opb(opb), .mbit(mbit),
    .ex_valid(ex_valid), .ex_idx(ex_idx), .ex_last(ex_last), .ex_wa(ex_wa),
    .ex_wm(ex_wm), .ex_data(ex_data), .ex_mbit(ex_mbit)
  );
endmodule

// File: rtl/vmx_exec_chk.sv
module vmx_exec_chk #(
  parameter int ELEMS = 64,
  localparam int LW   = $clog2(ELEMS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic             busy,
  input logic             done,
  input logic [ELEMS-1:0] mask_out,
  input logic [LW-1:0]    vl_out
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op <= 3'd2) |=> busy);
  // R9
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cmd_valid && cmd_ready)) |=> $stable(mask_out));
  // R9
  busy_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(vl_out));
  // R6
  vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_out >= LW'(1)) && (vl_out <= LW'(ELEMS)));
endmodule

bind vmask_exec vmx_exec_chk #(.ELEMS(ELEMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .busy(busy), .done(done), .mask_out(mask_out), .vl_out(vl_out)
);

// File: tb/vmask_exec_bench.sv
`timescale 1ns/1ps
module vmask_exec_bench;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, ld_valid = 0, ld_sel = 0, rd_sel = 0;
  logic [2:0]  cmd_op = 0;
  logic [63:0] cmd_arg = 0, ld_data = 0, rd_data, mask_out;
  logic [5:0]  ld_idx = 0, rd_idx = 0;
  logic [6:0]  vl_out;
  logic        cmd_ready, ld_ready, busy, done;

  int n_chk = 0, n_bad = 0;
  logic [63:0] ma [64];
  logic [63:0] mb [64];
  logic [63:0] mm;
  int          mvl;

  always #5 clk = ~clk;

  vmask_exec u_vmask_exec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_idx(ld_idx), .ld_data(ld_data), .rd_sel(rd_sel),
    .rd_idx(rd_idx), .rd_data(rd_data), .mask_out(mask_out), .vl_out(vl_out),
    .busy(busy), .done(done)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(logic sel, int idx, logic [63:0] d);
    ld_valid = 1; ld_sel = sel; ld_idx = 6'(idx); ld_data = d;
    @(posedge clk); #1;
    ld_valid = 0;
    if (sel) mb[idx] = d; else ma[idx] = d;
  endtask

  task automatic load_all(logic [63:0] scal, bit use_scal);
    for (int i = 0; i < 64; i++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (use_scal && ($urandom % 3 == 0)) v = scal;
      load(0, i, v);
      load(1, i, {$urandom, $urandom});
    end
  endtask

  task automatic verify(string tag);
    for (int i = 0; i < 64; i++) begin
      rd_sel = 0; rd_idx = 6'(i); #0.05;
      chk({tag, " R2 A"}, rd_data, ma[i]);
      rd_sel = 1; #0.05;
      chk({tag, " R2 B"}, rd_data, mb[i]);
    end
    chk({tag, " mask"}, mask_out, mm);
    chk({tag, " R6 vl"}, 64'(vl_out), 64'(mvl));
  endtask

  task automatic model(int op, logic [63:0] arg);
    case (op)
      0: for (int i = 0; i < mvl; i++) mm[i] = (ma[i] != arg);
      1: for (int i = 0; i < mvl; i++) if (mm[i]) ma[i] = ma[i] - mb[i];
      2: for (int i = 0; i < mvl; i++) ma[i] = ma[i] + mb[i];
      3: mm = '1;
      4: mvl = (arg == 0) ? 1 : (arg > 64) ? 64 : int'(arg);
      default: ;
    endcase
  endtask

  task automatic run_op(string tag, int op, logic [63:0] arg, bit poke);
    int n;
    cmd_valid = 1; cmd_op = 3'(op); cmd_arg = arg;
    @(posedge clk); #1;
    cmd_valid = 0;
    if (op <= 2) begin
      chk({tag, " R8 busy after accept"}, 64'(busy), 64'd1);
      if (poke) begin
        chk({tag, " R9 ready low"}, 64'({cmd_ready, ld_ready}), 64'd0);
        cmd_valid = 1; cmd_op = 3'd3; ld_valid = 1; ld_sel = 0;
        ld_idx = 0; ld_data = 64'hDEAD_BEEF_0BAD_F00D;
      end
      n = 1;
      do begin
        @(posedge clk); #1;
        n++;
        cmd_valid = 0; ld_valid = 0;
      end while (!done && n < 200);
      chk({tag, " R8 done latency"}, 64'(n), 64'(mvl + 2));
      chk({tag, " R8 idle at done"}, 64'(busy), 64'd0);
      model(op, arg);
      verify({tag, " R3 R4 R5"});
      @(posedge clk); #1;
      chk({tag, " R8 done one cycle"}, 64'(done), 64'd0);
    end else begin
      chk({tag, " R10 no busy/done"}, 64'({busy, done}), 64'd0);
      model(op, arg);
      verify({tag, " R6 R7 R10"});
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] s;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 mask reset", mask_out, '1);
    chk("R1 vl reset", 64'(vl_out), 64'd64);
    chk("R1 idle", 64'({busy, done, cmd_ready}), 64'b001);
    mm = '1; mvl = 64;

    s = {$urandom, $urandom};
    load_all(s, 1);
    verify("R2 load");
    run_op("R3 cmp full", 0, s, 0);
    run_op("R4 sub full", 1, 0, 0);
    run_op("R7 mset", 3, 0, 0);
    run_op("R6 vl10", 4, 10, 0);
    s = ma[3];
    run_op("R3 cmp vl10", 0, s, 0);
    run_op("R4 sub vl10", 1, 0, 1);
    run_op("R5 add vl10 R9 poke", 2, 0, 1);
    run_op("R6 vl0", 4, 0, 0);
    run_op("R8 add vl1", 2, 0, 0);
    run_op("R6 vl200", 4, 200, 0);
    run_op("R10 op5", 5, 7, 0);
    run_op("R10 op6", 6, 7, 0);
    run_op("R10 op7", 7, 7, 0);
    run_op("R5 add vl64", 2, 0, 0);

    for (int it = 0; it < 14; it++) begin
      int op;
      if (it % 4 == 0) begin
        s = {$urandom, $urandom};
        load_all(s, 1);
      end
      op = int'($urandom % 6);
      if (op == 5) run_op("rnd R6", 4, 64'($urandom % 70), 0);
      else if (op == 0) run_op("rnd R3", 0, ma[$urandom % 64], 0);
      else run_op("rnd", op, 0, (it % 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule